// File: doc/BRIEF.md
# Programmable Frame Pulse Generator

This block produces a frame-start pulse from two cascaded counters. A pixel counter wraps at a programmed pixels-per-line value, and a line counter advances on each pixel wrap and wraps at a programmed lines-per-frame value. The pulse stays high for the whole of line 0, so it lasts one programmed line of counting clocks. It repeats once every pixels-per-line times lines-per-frame counting clocks. For example, 1728 pixels by 625 lines on a 27 MHz clock gives one pulse every 1,080,000 cycles, which is 25 Hz. A high-definition rate can be built from the same 27 MHz clock by choosing other factors: 2002 by 225 gives the same frame rate as 2200 by 1125 at 148.35 MHz.

Two pixel-rate clocks are modelled as clock enables inside a single clock domain. A select bit chooses which enable drives the counters. A reference-line input is counted modulo a separately programmed reference lines-per-frame value. Each time that count completes, the counter chain is re-initialized, so the output frame keeps a fixed phase to the reference. Configuration is written through a small register port. New values reach the counters only at a frame boundary.

Top module: `frame_pulse_gen`

## Requirements
- R1: After reset all configuration registers read as zero and `frameOut` is low.
- R2: The select register (address 2, data bit 0) picks the counting enable: 0 selects `sdTick` and 1 selects `hdTick`. The enable that is not selected has no effect on counting.
- R3: With both counts legal, rising edges of `frameOut` are exactly pixels-per-line × lines-per-frame selected ticks apart.
- R4: `frameOut` rises at pixel 0 of line 0 and stays high for exactly pixels-per-line selected ticks, provided lines-per-frame is at least 2.
- R5: If pixels-per-line or lines-per-frame is zero, `frameOut` is held low once that value has been applied.
- R6: Configuration writes are held and applied only at a frame boundary: at a wrap, at a reference restart, or at once while the applied configuration is illegal. The frame in progress completes with the old values.
- R7: Pulses on `refLine` are counted modulo the reference lines-per-frame value (address 3). When the count completes, the counters restart on the next selected tick, and `frameOut` rises on that same edge. A reference value of zero disables the restart.
- R8: The register port writes 16-bit data on `cfgWrEn`. Address 0 holds pixels-per-line, address 1 holds lines-per-frame, address 2 holds the clock select and address 3 holds the reference lines-per-frame value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdTick | input | 1 | Standard-definition pixel clock enable |
| hdTick | input | 1 | High-definition pixel clock enable |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register address |
| cfgWrData | input | 16 | Configuration write data |
| refLine | input | 1 | One-cycle pulse per reference line |
| frameOut | output | 1 | Frame pulse, high during line 0 |

## Verification
On every cycle, the assertions check the following:
- both counters stay inside their applied limits;
- the counters hold still when neither an advance nor a restart strobe is present;
- the applied configuration changes only on a restart;
- every rising edge of `frameOut` coincides with the counters sitting at pixel 0 of line 0.

The pulse width and period in selected ticks can only be shown by the bench's scenarios. The same holds for:
- the effect of the clock select;
- a mid-frame write being deferred to the boundary;
- the hold-low behaviour of illegal counts;
- the timing of the reference restart.

The bench sweeps small configurations under two different tick patterns to cover these.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // a selected counting tick occurred
    logic restart;  // zero the counters and apply the held configuration
  } fpgStrobe_t;

  // Register addresses of the configuration port
  typedef enum logic [1:0] {
    ADDR_PPL = 2'd0,
    ADDR_LPF = 2'd1,
    ADDR_SEL = 2'd2,
    ADDR_REF = 2'd3
  } cfgAddr_t;

endpackage

// File: rtl/fpg_ctrl.sv
module fpg_ctrl
  import fpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgWrData,
  input  logic             sdTick,
  input  logic             hdTick,
  input  logic             refLine,
  input  logic             activeValid,
  input  logic             activeSel,
  input  logic             atEnd,
  output logic [CNT_W-1:0] heldPpl,
  output logic [CNT_W-1:0] heldLpf,
  output logic             heldSel,
  output fpgStrobe_t       strobe
);

  logic [CNT_W-1:0] heldRef;
  logic [CNT_W-1:0] refCnt;
  logic             refPending;
  logic             refEnabled;
  logic             refWrap;
  logic             tickSel;

  // Held configuration registers (R8)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      heldPpl <= '0;
      heldLpf <= '0;
      heldSel <= 1'b0;
      heldRef <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        ADDR_PPL: heldPpl <= cfgWrData;
        ADDR_LPF: heldLpf <= cfgWrData;
        ADDR_SEL: heldSel <= cfgWrData[0];
        ADDR_REF: heldRef <= cfgWrData;
        default:  ;
      endcase
    end
  end

  // Reference frame counter (R7)
  assign refEnabled = (heldRef != '0);
  assign refWrap    = refLine && refEnabled && (refCnt >= heldRef - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !refEnabled) begin
      refCnt <= '0;
    end else if (refWrap) begin
      refCnt <= '0;
    end else if (refLine) begin
      refCnt <= refCnt + CNT_W'(1);
    end
  end

  // Clock enable choice (R2)
  assign tickSel = activeSel ? hdTick : sdTick;

  // Frame boundary decision (R6, R7)
  always_comb begin
    strobe.advance = tickSel;
    strobe.restart = !activeValid || (tickSel && (atEnd || refPending));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refPending <= 1'b0;
    end else if (refWrap) begin
      refPending <= 1'b1;
    end else if (strobe.restart) begin
      refPending <= 1'b0;
    end
  end

endmodule

// File: rtl/fpg_datapath.sv
module fpg_datapath
  import fpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fpgStrobe_t       strobe,
  input  logic [CNT_W-1:0] heldPpl,
  input  logic [CNT_W-1:0] heldLpf,
  input  logic             heldSel,
  output logic             frameOut,
  output logic             atEnd,
  output logic             activeValid,
  output logic             activeSel
);

  logic [CNT_W-1:0] actPpl;
  logic [CNT_W-1:0] actLpf;
  logic [CNT_W-1:0] pix;
  logic [CNT_W-1:0] line;
  logic             pixLast;

  assign activeValid = (actPpl != '0) && (actLpf != '0);
  assign pixLast     = (pix == actPpl - CNT_W'(1));
  assign atEnd       = activeValid && pixLast && (line == actLpf - CNT_W'(1));
  assign frameOut    = activeValid && (line == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actPpl    <= '0;
      actLpf    <= '0;
      activeSel <= 1'b0;
      pix       <= '0;
      line      <= '0;
    end else if (strobe.restart) begin
      actPpl    <= heldPpl;
      actLpf    <= heldLpf;
      activeSel <= heldSel;
      pix       <= '0;
      line      <= '0;
    end else if (strobe.advance && activeValid) begin
      if (pixLast) begin
        pix  <= '0;
        line <= line + CNT_W'(1);
      end else begin
        pix <= pix + CNT_W'(1);
      end
    end
  end

  // R3: counters stay inside the applied limits
  p_pix_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    activeValid |-> (pix < actPpl));
  p_line_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    activeValid |-> (line < actLpf));

  // R2: with no strobe, no counting
  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.advance || strobe.restart) |=> ($stable(pix) && $stable(line)));

  // R6: applied configuration changes only on restart
  p_cfg_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.restart |=> ($stable(actPpl) && $stable(actLpf) && $stable(activeSel)));

  // R4: a pulse starts only at pixel 0 of line 0
  p_rise_at_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frameOut) |-> (pix == '0 && line == '0));

endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
  import fpg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdTick,
  input  logic             hdTick,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgWrData,
  input  logic             refLine,
  output logic             frameOut
);

  fpgStrobe_t       strobe;
  logic [CNT_W-1:0] heldPpl;
  logic [CNT_W-1:0] heldLpf;
  logic             heldSel;
  logic             activeValid;
  logic             activeSel;
  logic             atEnd;

  fpg_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgWrData  (cfgWrData),
    .sdTick     (sdTick),
    .hdTick     (hdTick),
    .refLine    (refLine),
    .activeValid(activeValid),
    .activeSel  (activeSel),
    .atEnd      (atEnd),
    .heldPpl    (heldPpl),
    .heldLpf    (heldLpf),
    .heldSel    (heldSel),
    .strobe     (strobe)
  );

  fpg_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .heldPpl    (heldPpl),
    .heldLpf    (heldLpf),
    .heldSel    (heldSel),
    .frameOut   (frameOut),
    .atEnd      (atEnd),
    .activeValid(activeValid),
    .activeSel  (activeSel)
  );

endmodule

// File: tb/test_frame_pulse_gen.sv
module test_frame_pulse_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdTick = 1'b0;
  logic        hdTick = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [15:0] cfgWrData = 16'd0;
  logic        refLine = 1'b0;
  logic        frameOut;

  int checks = 0;
  int fails = 0;
  int sdCnt = 0;
  int hdCnt = 0;
  int cyc = 0;

  frame_pulse_gen i_frame_pulse_gen (
    .clk(clk), .rst_n(rst_n), .sdTick(sdTick), .hdTick(hdTick),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .refLine(refLine), .frameOut(frameOut)
  );

  always #10 clk = ~clk;

  // Tick patterns: sd on every second cycle, hd on two of every three cycles
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      sdTick = (cyc % 2 == 0);
      hdTick = (cyc % 3 != 0);
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (sdTick) sdCnt <= sdCnt + 1;
      if (hdTick) hdCnt <= hdCnt + 1;
    end
  end

  function automatic int tickCount(input bit sel);
    return sel ? hdCnt : sdCnt;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Called at a negedge; performs one write cycle and returns at a negedge
  task automatic cfgWrite(input logic [1:0] addr, input int data);
    cfgWrEn = 1'b1;
    cfgAddr = addr;
    cfgWrData = 16'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setup(input int ppl, input int lpf, input bit sel);
    cfgWrite(2'd0, ppl);
    cfgWrite(2'd1, lpf);
    cfgWrite(2'd2, int'(sel));
  endtask

  task automatic waitRise();
    while (frameOut) @(negedge clk);
    while (!frameOut) @(negedge clk);
  endtask

  // Called at the first sample where frameOut is high
  task automatic measureHere(input int ppl, input int lpf, input bit sel, input string tag);
    int c0, c1, c2;
    c0 = tickCount(sel);
    while (frameOut) @(negedge clk);
    c1 = tickCount(sel);
    while (!frameOut) @(negedge clk);
    c2 = tickCount(sel);
    check({"R4 width ", tag}, c1 - c0, ppl);
    check({"R3 period ", tag}, c2 - c0, ppl * lpf);
  endtask

  task automatic refPulse();
    refLine = 1'b1;
    @(negedge clk);
    refLine = 1'b0;
  endtask

  initial begin
    int highs;
    int cr, cf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, output low with zero configuration
    highs = 0;
    repeat (8) begin
      if (frameOut) highs++;
      @(negedge clk);
    end
    check("R1 low after reset", highs, 0);

    // R2 R3 R4 R8: sweep of small configurations on both tick sources
    for (int sel = 0; sel < 2; sel++) begin
      for (int ppl = 1; ppl <= 3; ppl++) begin
        for (int lpf = 2; lpf <= 3; lpf++) begin
          setup(ppl, lpf, sel[0]);
          waitRise();
          waitRise();
          measureHere(ppl, lpf, sel[0],
                      $sformatf("R2 R8 ppl=%0d lpf=%0d sel=%0d", ppl, lpf, sel));
        end
      end
    end

    // R6: a write during a frame leaves that frame intact
    setup(5, 3, 1'b0);
    waitRise();
    waitRise();
    cr = tickCount(1'b0);
    setup(2, 2, 1'b1);
    while (frameOut) @(negedge clk);
    cf = tickCount(1'b0);
    check("R6 old width kept", cf - cr, 5);
    while (!frameOut) @(negedge clk);
    check("R6 old period kept", tickCount(1'b0) - cr, 15);
    measureHere(2, 2, 1'b1, "R6 new config from boundary");

    // R5: zero lines-per-frame holds output low
    cfgWrite(2'd1, 0);
    repeat (100) @(negedge clk);
    highs = 0;
    repeat (50) begin
      if (frameOut) highs++;
      @(negedge clk);
    end
    check("R5 lpf zero holds low", highs, 0);

    // R5: zero pixels-per-line holds output low
    cfgWrite(2'd1, 2);
    cfgWrite(2'd0, 0);
    repeat (100) @(negedge clk);
    highs = 0;
    repeat (50) begin
      if (frameOut) highs++;
      @(negedge clk);
    end
    check("R5 ppl zero holds low", highs, 0);

    // R7: reference restart, modulo two reference lines
    setup(4, 3, 1'b0);
    cfgWrite(2'd3, 2);
    waitRise();
    waitRise();
    while (frameOut) @(negedge clk);
    refPulse();
    repeat (2) @(negedge clk);
    check("R7 single ref pulse no restart", int'(frameOut), 0);
    refPulse();
    cr = tickCount(1'b0);
    while (!frameOut) @(negedge clk);
    check("R7 restart on next selected tick", tickCount(1'b0) - cr, 1);
    measureHere(4, 3, 1'b0, "R7 after ref restart");

    // R7: reference value zero disables the restart
    cfgWrite(2'd3, 0);
    waitRise();
    while (frameOut) @(negedge clk);
    cf = tickCount(1'b0);
    refPulse();
    refPulse();
    refPulse();
    while (!frameOut) @(negedge clk);
    check("R7 disabled ref no restart", tickCount(1'b0) - cf, 8);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule